// File: doc/BRIEF.md
# Conversion Result Window Comparator

This block sits after a sampling converter and decides, for each finished conversion, whether the conversion-complete flag goes up. Every result arrives with a one-cycle valid strobe. The block trims the result to the active resolution and compares it with a programmed level. The comparison adds the result to the one's complement of the level with a carry-in of one, so the carry out of the sum gives the ordering. The block reports a match bit for each result.

In single-result operation, the complete flag follows the match directly. In batch operation the block counts results up to a programmed batch length. It then combines the match bits of the whole batch with either AND or OR, and raises the complete flag at the end of the batch if the combined value holds. The complete flag stays up until a clear strobe arrives. The clear strobe also restarts batch counting.

Top module: `adc_window_cmp`

## Requirements
- R1: With compare mode 0 the compare is disabled: `match_o` reads 1 for every result, and in single-result mode every result sets `done_o`.
- R2: Compare mode 1 is reserved and behaves exactly as mode 0.
- R3: With compare mode 2 a result matches when it is strictly less than the compare level.
- R4: With compare mode 3 a result matches when it is greater than or equal to the compare level, so equality matches.
- R5: Resolution select 0 keeps the low 8 bits, 1 keeps the low 10 bits, and 2 or 3 keeps all 12 bits. The bits above the active width are ignored in both the result and the compare level.
- R6: In single-result mode with the compare enabled, a non-matching result leaves `done_o` unchanged.
- R7: In batch mode with `and_mode_i`=1, a batch is `depth_i`+1 results long. At the end of a batch, `done_o` is set only if every result in that batch matched. Earlier results in the batch never set it.
- R8: In batch mode with `and_mode_i`=0, `done_o` is set at the end of a batch if at least one result in that batch matched.
- R9: `done_o` stays set until `clr_i` is asserted, and is low on the edge after a clear. A clear restarts the batch. A result presented in the same cycle as `clr_i` is reported on `match_o` but does not count toward completion.
- R10: `match_valid_o` and `match_o` appear on the clock edge after the cycle in which `valid_i` was high. `match_valid_o` is high for one cycle for each result.
- R11: After reset, `done_o`, `match_o` and `match_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_sel_i | input | 2 | Resolution select (0: 8, 1: 10, 2/3: 12 bits) |
| cmp_mode_i | input | 2 | Compare mode (0/1 off, 2 less-than, 3 greater-or-equal) |
| cmp_val_i | input | RES_W | Compare level |
| fifo_en_i | input | 1 | Batch mode enable |
| depth_i | input | DEPTH_W | Batch length minus one |
| and_mode_i | input | 1 | 1: AND aggregation, 0: OR aggregation |
| valid_i | input | 1 | Result strobe |
| result_i | input | RES_W | Conversion result |
| clr_i | input | 1 | Clear the complete flag and the batch state |
| match_o | output | 1 | Match bit of the last result |
| match_valid_o | output | 1 | `match_o` is valid this cycle |
| done_o | output | 1 | Conversion-complete flag |

## Verification
The hardest cases involve batch aggregation. One is an AND batch with a single non-match in the middle, which must never set the flag. The other is an OR batch where the only match comes from the last result. The bench reaches both by driving back-to-back results with a chosen compare level, so that each result's match bit is known. It also checks the flag after every result of a batch, not only the last. It also drives a clear together with a result strobe, to confirm that this result is reported but does not count toward completion. It also presents results and compare levels with bits set above the active width, to confirm that those bits are ignored.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;
  typedef enum logic [1:0] {
    CMP_OFF  = 2'd0,
    CMP_RSVD = 2'd1,
    CMP_LT   = 2'd2,
    CMP_GE   = 2'd3
  } cmp_mode_e;

  typedef enum logic [1:0] {
    RES_8    = 2'd0,
    RES_10   = 2'd1,
    RES_12   = 2'd2,
    RES_XTRA = 2'd3
  } res_sel_e;

  function automatic int unsigned res_bits(logic [1:0] sel);
    case (sel)
      RES_8:   return 8;
      RES_10:  return 10;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/adc_cmp_mask.sv
module adc_cmp_mask #(
  parameter int unsigned W = 12
) (
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o
);
  import adc_cmp_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign data_o[i] = data_i[i] & (res_bits(sel_i) > i);
  end
endmodule

// File: rtl/adc_cmp_core.sv
module adc_cmp_core #(
  parameter int unsigned W = 12
) (
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] res_i,
  input  logic [W-1:0] lvl_i,
  output logic         en_o,
  output logic         hit_o
);
  import adc_cmp_pkg::*;

  logic [W:0] sum;
  logic       ge;

  // result + ~level + 1: carry out means result >= level
  assign sum = {1'b0, res_i} + {1'b0, ~lvl_i} + {{W{1'b0}}, 1'b1};
  assign ge  = sum[W];

  always_comb begin
    en_o  = 1'b0;
    hit_o = 1'b1;
    case (cmp_mode_e'(mode_i))
      CMP_LT: begin en_o = 1'b1; hit_o = ~ge; end
      CMP_GE: begin en_o = 1'b1; hit_o = ge;  end
      default: ;
    endcase
  end
endmodule

// File: rtl/adc_cmp_aggr.sv
module adc_cmp_aggr #(
  parameter int unsigned DEPTH_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               clr_i,
  input  logic               hit_i,
  input  logic               fifo_en_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic               and_mode_i,
  output logic               done_o
);
  logic [DEPTH_W-1:0] cnt_q;
  logic               acc_q, done_q;
  logic               first, last, agg;

  assign first = (cnt_q == '0);
  assign last  = ~fifo_en_i | (cnt_q >= depth_i);
  assign agg   = and_mode_i ? ((first | acc_q) & hit_i)
                            : ((~first & acc_q) | hit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      acc_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      acc_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (valid_i) begin
      if (last) begin
        cnt_q  <= '0;
        acc_q  <= 1'b0;
        done_q <= done_q | agg;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        acc_q <= agg;
      end
    end
  end

  assign done_o = done_q;

  assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !clr_i |=> done_q);
  assert_clr_drops_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !done_q);
  assert_mid_batch_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !clr_i && fifo_en_i && (cnt_q < depth_i) |=> $stable(done_q));
endmodule

// File: rtl/adc_window_cmp.sv
module adc_window_cmp #(
  parameter int unsigned RES_W   = 12,
  parameter int unsigned DEPTH_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         res_sel_i,
  input  logic [1:0]         cmp_mode_i,
  input  logic [RES_W-1:0]   cmp_val_i,
  input  logic               fifo_en_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic               and_mode_i,
  input  logic               valid_i,
  input  logic [RES_W-1:0]   result_i,
  input  logic               clr_i,
  output logic               match_o,
  output logic               match_valid_o,
  output logic               done_o
);
  logic [RES_W-1:0] res_m, lvl_m;
  logic             cmp_en, hit;
  logic             match_q, mvalid_q;

  adc_cmp_mask #(.W(RES_W)) u_mask_res (.sel_i(res_sel_i), .data_i(result_i),  .data_o(res_m));
  adc_cmp_mask #(.W(RES_W)) u_mask_lvl (.sel_i(res_sel_i), .data_i(cmp_val_i), .data_o(lvl_m));

  adc_cmp_core #(.W(RES_W)) u_core (
    .mode_i(cmp_mode_i), .res_i(res_m), .lvl_i(lvl_m), .en_o(cmp_en), .hit_o(hit)
  );

  adc_cmp_aggr #(.DEPTH_W(DEPTH_W)) u_aggr (
    .clk_i, .rst_ni, .valid_i, .clr_i, .hit_i(hit), .fifo_en_i, .depth_i,
    .and_mode_i, .done_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q  <= 1'b0;
      mvalid_q <= 1'b0;
    end else begin
      mvalid_q <= valid_i;
      if (valid_i) match_q <= hit;
    end
  end

  assign match_o       = match_q;
  assign match_valid_o = mvalid_q;

  assert_valid_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> match_valid_o);
  assert_off_sets_done_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !clr_i && !fifo_en_i && !cmp_en |=> done_o && match_o);
  assert_miss_no_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !clr_i && !fifo_en_i && cmp_en && !hit && !done_o |=> !done_o);
endmodule

// File: tb/adc_window_cmp_test.sv
module adc_window_cmp_test;
  localparam int PERIOD = 10;
  localparam int RW = 12;
  localparam int DW = 3;

  logic clk = 0, rst_n = 0;
  logic [1:0] res_sel = 2, cmp_mode = 0;
  logic [RW-1:0] cmp_val = 0, result = 0;
  logic fifo_en = 0, and_mode = 0, valid = 0, clr = 0;
  logic [DW-1:0] depth = 0;
  logic match, mvalid, done;

  int checks = 0, fails = 0;
  logic [1:0] sb_q[$];
  string tag_q[$];
  bit exp_done = 0, b_acc = 0;
  int b_cnt = 0;

  always #(PERIOD/2) clk = ~clk;

  adc_window_cmp #(.RES_W(RW), .DEPTH_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .res_sel_i(res_sel), .cmp_mode_i(cmp_mode),
    .cmp_val_i(cmp_val), .fifo_en_i(fifo_en), .depth_i(depth), .and_mode_i(and_mode),
    .valid_i(valid), .result_i(result), .clr_i(clr), .match_o(match),
    .match_valid_o(mvalid), .done_o(done));

  task automatic check(input logic [RW-1:0] act, input logic [RW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int width_of(input logic [1:0] s);
    return (s == 0) ? 8 : (s == 1) ? 10 : 12;
  endfunction

  // driver: one result, expectation pushed into scoreboard
  task automatic drive(input logic [RW-1:0] r, input bit with_clr, input string tag);
    int w;
    int unsigned rm, cm;
    bit m, first, last, agg;
    @(negedge clk);
    w = width_of(res_sel);
    rm = int'(r) % (1 << w);
    cm = int'(cmp_val) % (1 << w);
    m = (cmp_mode == 2) ? (rm < cm) : (cmp_mode == 3) ? (rm >= cm) : 1'b1;
    if (with_clr) begin
      exp_done = 0; b_cnt = 0; b_acc = 0;
    end else begin
      first = (b_cnt == 0);
      last  = !fifo_en || (b_cnt >= int'(depth));
      agg   = and_mode ? ((first || b_acc) && m) : ((!first && b_acc) || m);
      if (last) begin
        exp_done = exp_done | agg; b_cnt = 0; b_acc = 0;
      end else begin
        b_cnt++; b_acc = agg;
      end
    end
    sb_q.push_back({m, exp_done});
    tag_q.push_back(tag);
    result = r; valid = 1; clr = with_clr;
    @(negedge clk);
    valid = 0; clr = 0;
  endtask

  task automatic clear(input string tag);
    @(negedge clk);
    clr = 1;
    @(negedge clk);
    clr = 0;
    exp_done = 0; b_cnt = 0; b_acc = 0;
    check(RW'(done), RW'(0), tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && mvalid) begin
      logic [1:0] e;
      string t;
      if (sb_q.size() == 0) begin
        check(RW'(1), RW'(0), "R10 unexpected match_valid");
      end else begin
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        check(RW'(match), RW'(e[1]), {t, " match"});
        check(RW'(done),  RW'(e[0]), {t, " done"});
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(RW'({done, match, mvalid}), RW'(0), "R11 reset state");
    rst_n = 1;
    @(negedge clk);
    check(RW'({done, match, mvalid}), RW'(0), "R11 after release");

    cmp_mode = 0; drive(12'h123, 0, "R1 mode off");
    clear("R9 clear");
    cmp_mode = 1; drive(12'h000, 0, "R2 reserved mode");
    clear("R9 clear");

    cmp_mode = 2; cmp_val = 200;
    drive(200, 0, "R3 lt equal no match R6");
    drive(201, 0, "R3 lt above R6");
    drive(100, 0, "R3 lt below");
    drive(300, 0, "R9 sticky after miss");
    clear("R9 clear");
    cmp_mode = 3;
    drive(199, 0, "R4 ge below R6");
    drive(200, 0, "R4 ge equal");
    clear("R9 clear");
    cmp_val = 0; drive(0, 0, "R4 ge zero");
    clear("R9 clear");

    res_sel = 0; cmp_mode = 3; cmp_val = 12'h1FF;
    drive(12'h3FE, 0, "R5 8-bit ge masked");
    cmp_mode = 2; drive(12'h3FE, 0, "R5 8-bit lt masked");
    clear("R9 clear");
    res_sel = 1; cmp_mode = 3; cmp_val = 12'h5FF;
    drive(12'hE00, 0, "R5 10-bit ge masked");
    clear("R9 clear");
    res_sel = 3; cmp_val = 12'hFFF;
    drive(12'hFFE, 0, "R5 12-bit sel3");
    drive(12'hFFF, 0, "R5 12-bit sel3 equal");
    clear("R9 clear");

    res_sel = 2; cmp_mode = 3; cmp_val = 100;
    fifo_en = 1; depth = 2; and_mode = 1;
    drive(150, 0, "R7 and b1 r1");
    drive(160, 0, "R7 and b1 r2");
    drive(170, 0, "R7 and b1 r3");
    clear("R9 clear");
    drive(150, 0, "R7 and b2 r1");
    drive(50,  0, "R7 and b2 miss");
    drive(170, 0, "R7 and b2 r3");
    drive(150, 0, "R7 and b3 r1");
    drive(150, 0, "R7 and b3 r2");
    drive(150, 0, "R7 and b3 r3");
    clear("R9 clear");

    and_mode = 0; depth = 3;
    drive(10, 0, "R8 or b1 r1");
    drive(10, 0, "R8 or b1 r2");
    drive(10, 0, "R8 or b1 r3");
    drive(10, 0, "R8 or b1 r4");
    drive(10, 0, "R8 or b2 r1");
    drive(10, 0, "R8 or b2 r2");
    drive(10, 0, "R8 or b2 r3");
    drive(500, 0, "R8 or b2 last hit");
    clear("R9 clear");

    fifo_en = 0; cmp_mode = 3;
    drive(500, 1, "R9 valid with clear");
    drive(50, 0, "R9 miss after clear");
    drive(500, 0, "R9 hit after clear");
    clear("R9 final clear");

    repeat (4) @(negedge clk);
    check(RW'(sb_q.size()), RW'(0), "R10 scoreboard drained");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule